// File: doc/BRIEF.md
# Preload hint decoder and address generator

This block sits beside the execute stage of a processor and picks out the register-offset data-preload hint from the instruction stream. It accepts a 32-bit instruction word with a flag that says whether the word is a fixed-length 32-bit encoding or a compact encoding made of two halfwords, with the first halfword in bits [31:16]. When the word is a preload hint, the block uses its register fields to drive two register-file read indices. The register file returns the base and index values in the same cycle, together with the carry flag. The block then forms the effective address.

The fixed-length form can shift the index by any immediate amount, using a logical left shift, a logical right shift, an arithmetic right shift or a rotate. It also supports a one-bit rotate through the carry flag, and it can add or subtract the offset. The compact form always adds the index after a left shift of 0 to 3 bits. One cycle after the input, the block presents a registered hint that carries the intent (read or write), the address, and flags for unpredictable and reserved encodings. A compact word whose base field is all ones belongs to the literal form. For that word the block raises a redirect pulse and produces no hint.

Top module: `pref_hint_agu`

## Requirements
- R1: A fixed-length word (in_compact=0) matches when bits[31:25]=1111011, bit24=1, bits[21:20]=01 and bit4=0. The hint then appears on hint_valid one clock after in_valid. Bit22 gives the intent: 1 means read (hint_write=0) and 0 means write (hint_write=1).
- R2: In the fixed-length form, bit23=1 adds the shifted index to the base and bit23=0 subtracts it. The result wraps modulo 2^32.
- R3: In the fixed-length form, the immediate shift amount is in bits[11:7] and the shift kind is in bits[6:5]: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right. A non-zero amount n shifts the index by n.
- R4: In the fixed-length form, an amount of 0 has a different meaning for each shift kind. For a left shift it means no shift. For a logical right shift it means a shift of 32, which gives zero. For an arithmetic right shift it means a shift of 32, which fills the value with the index sign bit. For a rotate it means a one-bit rotate right with carry_in entering bit 31.
- R5: A fixed-length hint is still issued but sets hint_unpred when the index field bits[3:0]=1111, or when the base field bits[19:16]=1111 with write intent. A base field of 1111 with read intent is legal and leaves hint_unpred clear.
- R6: A fixed-length hint whose bits[15:12] are not 1111 is still issued, with hint_reserved set.
- R7: A compact word (in_compact=1) matches when bits[31:22]=1111100000, bit20=1, bits[15:12]=1111 and bits[11:6]=0. Bit21=1 means write intent. The address is the base plus the index shifted left by bits[5:4].
- R8: A matching compact word with base field bits[19:16]=1111 produces a one-cycle lit_redirect pulse one clock later and no hint.
- R9: A compact hint with index field bits[3:0]=1111 is issued with hint_unpred set.
- R10: A word that matches neither form, or any word presented with in_valid low, produces neither hint_valid nor lit_redirect.
- R11: rf_base_sel always equals bits[19:16] and rf_index_sel always equals bits[3:0] of the current word, in the same cycle.
- R12: While rst_n is low at a clock edge, hint_valid, hint_write, hint_unpred, hint_reserved and lit_redirect are cleared, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| in_word | input | 32 | Instruction word (compact form: first halfword in [31:16]) |
| in_compact | input | 1 | 1 = compact two-halfword form, 0 = fixed-length form |
| rf_base_sel | output | 4 | Register-file read index for the base |
| rf_index_sel | output | 4 | Register-file read index for the index |
| rf_base | input | 32 | Base register value (program counter when the index is 15) |
| rf_index | input | 32 | Index register value |
| carry_in | input | 1 | Carry flag, used by the one-bit rotate |
| hint_valid | output | 1 | Registered hint present |
| hint_write | output | 1 | Hint intent: 1 write, 0 read |
| hint_addr | output | 32 | Effective address of the hint |
| hint_unpred | output | 1 | Hint came from an unpredictable encoding |
| hint_reserved | output | 1 | Hint came from a word with non-one reserved bits |
| lit_redirect | output | 1 | Word belongs to the literal preload form |

## Verification
Some properties are checked by assertions on every cycle. A hint and a redirect never appear together. A hint or any of its flags only appears after an accepted input. An index field of all ones always sets the unpredictable flag. A compact hint with a zero shift always yields base plus index. The bench scenarios are the only way to show the other behaviours. These include the zero-amount meaning for each shift kind, the carry entering the rotate, subtraction that wraps, the reserved flag, the rule that makes a base of 15 legal for a read, and the rejection of near-miss words.

// File: rtl/pref_hint_pkg.sv
package pref_hint_pkg;
  localparam int PH_XLEN   = 32;
  localparam int PH_RIDX_W = 4;
  localparam int PH_SHAMT_W = $clog2(PH_XLEN) + 1;
  localparam logic [PH_RIDX_W-1:0] PH_REG_ALL1 = '1;

  typedef enum logic [2:0] {
    SHK_LSL = 3'd0,
    SHK_LSR = 3'd1,
    SHK_ASR = 3'd2,
    SHK_ROR = 3'd3,
    SHK_RRX = 3'd4
  } shk_e;

  typedef struct packed {
    logic                  is_hint;
    logic                  is_lit;
    logic                  write;
    logic                  sub;
    logic                  unpred;
    logic                  rsvd;
    shk_e                  kind;
    logic [PH_SHAMT_W-1:0] amt;
  } dec_t;

  // Shift the index value by the decoded kind and amount; amt may reach XLEN.
  function automatic logic [PH_XLEN-1:0] shift_apply(
      input logic [PH_XLEN-1:0]    v,
      input shk_e                  kind,
      input logic [PH_SHAMT_W-1:0] amt,
      input logic                  c);
    logic [PH_SHAMT_W-2:0] rot;
    rot = amt[PH_SHAMT_W-2:0];
    case (kind)
      SHK_LSL: shift_apply = (amt >= PH_SHAMT_W'(PH_XLEN)) ? '0 : (v << amt);
      SHK_LSR: shift_apply = (amt >= PH_SHAMT_W'(PH_XLEN)) ? '0 : (v >> amt);
      SHK_ASR: shift_apply = (amt >= PH_SHAMT_W'(PH_XLEN)) ? {PH_XLEN{v[PH_XLEN-1]}}
                                                           : PH_XLEN'($signed(v) >>> amt);
      SHK_ROR: shift_apply = (v >> rot) | (v << (PH_XLEN - int'(rot)));
      default: shift_apply = {c, v[PH_XLEN-1:1]};
    endcase
  endfunction
endpackage

// File: rtl/pref_hint_decode.sv
module pref_hint_decode
  import pref_hint_pkg::*;
(
  input  logic [31:0]          word,
  input  logic                 compact,
  output logic [PH_RIDX_W-1:0] base_sel,
  output logic [PH_RIDX_W-1:0] index_sel,
  output dec_t                 dec
);
  logic [PH_RIDX_W-1:0] rn, rm;
  logic                 fx_match, cp_match, fx_write, cp_write;
  logic [4:0]           fx_imm;
  logic [1:0]           fx_st;

  assign rn = word[19:16];
  assign rm = word[3:0];
  assign base_sel  = rn;
  assign index_sel = rm;

  assign fx_match = (word[31:25] == 7'b1111011) && word[24] &&
                    (word[21:20] == 2'b01) && !word[4];
  assign cp_match = (word[31:22] == 10'b1111100000) && word[20] &&
                    (word[15:12] == 4'hF) && (word[11:6] == 6'd0);
  assign fx_write = !word[22];
  assign cp_write = word[21];
  assign fx_imm   = word[11:7];
  assign fx_st    = word[6:5];

  always_comb begin
    dec = '0;
    dec.kind = SHK_LSL;
    if (!compact) begin
      dec.is_hint = fx_match;
      dec.write   = fx_write;
      dec.sub     = !word[23];
      dec.unpred  = (rm == PH_REG_ALL1) || ((rn == PH_REG_ALL1) && fx_write);
      dec.rsvd    = (word[15:12] != 4'hF);
      dec.amt     = PH_SHAMT_W'(fx_imm);
      case (fx_st)
        2'b00: dec.kind = SHK_LSL;
        2'b01: dec.kind = SHK_LSR;
        2'b10: dec.kind = SHK_ASR;
        default: dec.kind = SHK_ROR;
      endcase
      if (fx_imm == 5'd0) begin
        if (fx_st == 2'b01 || fx_st == 2'b10) dec.amt = PH_SHAMT_W'(PH_XLEN);
        else if (fx_st == 2'b11) begin
          dec.kind = SHK_RRX;
          dec.amt  = PH_SHAMT_W'(1);
        end
      end
    end else begin
      dec.is_hint = cp_match && (rn != PH_REG_ALL1);
      dec.is_lit  = cp_match && (rn == PH_REG_ALL1);
      dec.write   = cp_write;
      dec.sub     = 1'b0;
      dec.unpred  = (rm == PH_REG_ALL1);
      dec.rsvd    = 1'b0;
      dec.kind    = SHK_LSL;
      dec.amt     = PH_SHAMT_W'(word[5:4]);
    end
  end
endmodule

// File: rtl/pref_hint_shifter.sv
module pref_hint_shifter
  import pref_hint_pkg::*;
(
  input  logic [PH_XLEN-1:0]    src,
  input  shk_e                  kind,
  input  logic [PH_SHAMT_W-1:0] amt,
  input  logic                  carry,
  output logic [PH_XLEN-1:0]    result
);
  assign result = shift_apply(src, kind, amt, carry);
endmodule

// File: rtl/pref_hint_agu.sv
module pref_hint_agu
  import pref_hint_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  input  logic        in_compact,
  output logic [3:0]  rf_base_sel,
  output logic [3:0]  rf_index_sel,
  input  logic [31:0] rf_base,
  input  logic [31:0] rf_index,
  input  logic        carry_in,
  output logic        hint_valid,
  output logic        hint_write,
  output logic [31:0] hint_addr,
  output logic        hint_unpred,
  output logic        hint_reserved,
  output logic        lit_redirect
);
  dec_t               dec;
  logic [PH_XLEN-1:0] offset_w;
  logic [PH_XLEN-1:0] ea_w;
  logic               issue_w;
  logic               redirect_w;

  pref_hint_decode u_dec (
    .word      (in_word),
    .compact   (in_compact),
    .base_sel  (rf_base_sel),
    .index_sel (rf_index_sel),
    .dec       (dec)
  );

  pref_hint_shifter u_shf (
    .src    (rf_index),
    .kind   (dec.kind),
    .amt    (dec.amt),
    .carry  (carry_in),
    .result (offset_w)
  );

  assign ea_w       = dec.sub ? (rf_base - offset_w) : (rf_base + offset_w);
  assign issue_w    = in_valid && dec.is_hint;
  assign redirect_w = in_valid && dec.is_lit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hint_valid    <= 1'b0;
      hint_write    <= 1'b0;
      hint_unpred   <= 1'b0;
      hint_reserved <= 1'b0;
      lit_redirect  <= 1'b0;
      hint_addr     <= '0;
    end else begin
      hint_valid    <= issue_w;
      hint_write    <= issue_w && dec.write;
      hint_unpred   <= issue_w && dec.unpred;
      hint_reserved <= issue_w && dec.rsvd;
      lit_redirect  <= redirect_w;
      if (issue_w) hint_addr <= ea_w;
    end
  end

  // R8: hint and literal redirect exclude each other
  p_hint_or_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hint_valid && lit_redirect));

  // R10: no output event without an accepted input one cycle earlier
  p_hint_needs_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hint_valid || lit_redirect) |-> $past(in_valid));

  // R6: flags only accompany a hint
  p_flags_need_hint_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hint_unpred || hint_reserved || hint_write) |-> hint_valid);

  // R9 (and R5): an all-ones index field always marks the hint unpredictable
  p_rm15_unpred_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hint_valid && $past(in_word[3:0]) == 4'hF) |-> hint_unpred);

  // R7: compact hint with zero shift is base plus index
  p_compact_plain_add_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hint_valid && $past(in_compact) && $past(in_word[5:4]) == 2'b00)
      |-> hint_addr == $past(rf_base) + $past(rf_index));
endmodule

// File: tb/pref_hint_agu_tb.sv
module pref_hint_agu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        in_compact = 1'b0;
  logic [3:0]  rf_base_sel, rf_index_sel;
  logic [31:0] rf_base = '0, rf_index = '0;
  logic        carry_in = 1'b0;
  logic        hint_valid, hint_write, hint_unpred, hint_reserved, lit_redirect;
  logic [31:0] hint_addr;

  int n_checks = 0;
  int n_fails  = 0;
  logic o_v, o_w, o_u, o_r, o_l;
  logic [31:0] o_a;

  always #5 clk = ~clk;

  pref_hint_agu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_compact(in_compact), .rf_base_sel(rf_base_sel), .rf_index_sel(rf_index_sel),
    .rf_base(rf_base), .rf_index(rf_index), .carry_in(carry_in),
    .hint_valid(hint_valid), .hint_write(hint_write), .hint_addr(hint_addr),
    .hint_unpred(hint_unpred), .hint_reserved(hint_reserved), .lit_redirect(lit_redirect)
  );

  function automatic logic [31:0] enc_fx(input logic u, input logic r, input logic [3:0] rn,
      input logic [3:0] rm, input logic [4:0] imm, input logic [1:0] st, input logic [3:0] sbo);
    return {7'b1111011, 1'b1, u, r, 2'b01, rn, sbo, imm, st, 1'b0, rm};
  endfunction

  function automatic logic [31:0] enc_cp(input logic w, input logic [3:0] rn,
      input logic [1:0] sh, input logic [3:0] rm);
    return {10'b1111100000, w, 1'b1, rn, 4'hF, 6'd0, sh, rm};
  endfunction

  // Reference offset, written from the requirement text with 64-bit helpers
  function automatic logic [31:0] ref_off(input logic [31:0] v, input logic [1:0] st,
      input logic [4:0] imm, input logic c);
    logic [63:0] dbl;
    logic [63:0] sx;
    int n;
    n = (imm == 0) ? 32 : int'(imm);
    dbl = {v, v};
    sx = {{32{v[31]}}, v};
    case (st)
      2'b00: return (imm == 0) ? v : v << imm;
      2'b01: return 32'({32'd0, v} >> n);
      2'b10: return 32'(sx >> n);
      default: return (imm == 0) ? {c, v[31:1]} : 32'(dbl >> imm);
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic cmp, input logic [31:0] b,
                       input logic [31:0] x, input logic c, input logic v = 1'b1);
    @(negedge clk);
    in_word = w; in_compact = cmp; rf_base = b; rf_index = x; carry_in = c; in_valid = v;
    @(posedge clk);
    #1;
    o_v = hint_valid; o_w = hint_write; o_u = hint_unpred;
    o_r = hint_reserved; o_l = lit_redirect; o_a = hint_addr;
    in_valid = 1'b0;
  endtask

  task automatic expect_hint(input string req, input logic w, input logic [31:0] a,
                             input logic u, input logic r);
    chk(req, "valid", 32'(o_v), 32'd1);
    chk(req, "write", 32'(o_w), 32'(w));
    chk(req, "addr", o_a, a);
    chk(req, "unpred", 32'(o_u), 32'(u));
    chk(req, "reserved", 32'(o_r), 32'(r));
    chk(req, "redirect", 32'(o_l), 32'd0);
  endtask

  task automatic t_reset();
    // R12: a valid word during reset must leave everything cleared
    issue(enc_fx(1, 1, 4'd2, 4'd3, 5'd0, 2'b00, 4'hF), 1'b0, 32'h100, 32'h4, 1'b0);
    chk("R12", "valid in reset", 32'(o_v), 32'd0);
    chk("R12", "write in reset", 32'(o_w), 32'd0);
    chk("R12", "redirect in reset", 32'(o_l), 32'd0);
    chk("R12", "unpred in reset", 32'(o_u), 32'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_fixed_basic();
    issue(enc_fx(1, 1, 4'd1, 4'd2, 5'd2, 2'b00, 4'hF), 1'b0, 32'h1000, 32'h10, 1'b0);
    expect_hint("R1", 1'b0, 32'h1040, 1'b0, 1'b0);
    issue(enc_fx(1, 0, 4'd1, 4'd2, 5'd2, 2'b00, 4'hF), 1'b0, 32'h1000, 32'h10, 1'b0);
    expect_hint("R1", 1'b1, 32'h1040, 1'b0, 1'b0);
    @(posedge clk); #1;
    chk("R1", "single pulse", 32'(hint_valid), 32'd0);
  endtask

  task automatic t_fixed_sub_wrap();
    issue(enc_fx(0, 1, 4'd5, 4'd6, 5'd0, 2'b00, 4'hF), 1'b0, 32'h10, 32'h20, 1'b0);
    expect_hint("R2", 1'b0, 32'hFFFF_FFF0, 1'b0, 1'b0);
    issue(enc_fx(1, 1, 4'd5, 4'd6, 5'd1, 2'b00, 4'hF), 1'b0, 32'hF000_0000, 32'h9000_0000, 1'b0);
    expect_hint("R2", 1'b0, 32'hF000_0000 + 32'h2000_0000, 1'b0, 1'b0);
  endtask

  task automatic t_fixed_shifts();
    logic [31:0] x;
    x = 32'h8765_4321;
    for (int st = 1; st < 4; st++) begin
      issue(enc_fx(1, 1, 4'd1, 4'd2, 5'd8, 2'(st), 4'hF), 1'b0, 32'h100, x, 1'b1);
      expect_hint("R3", 1'b0, 32'h100 + ref_off(x, 2'(st), 5'd8, 1'b1), 1'b0, 1'b0);
    end
    issue(enc_fx(0, 1, 4'd1, 4'd2, 5'd31, 2'b11, 4'hF), 1'b0, 32'h0, x, 1'b0);
    expect_hint("R3", 1'b0, 32'h0 - ref_off(x, 2'b11, 5'd31, 1'b0), 1'b0, 1'b0);
  endtask

  task automatic t_fixed_zero_amt();
    logic [31:0] x;
    x = 32'h8000_0003;
    issue(enc_fx(1, 1, 4'd1, 4'd2, 5'd0, 2'b00, 4'hF), 1'b0, 32'h100, x, 1'b0);
    expect_hint("R4", 1'b0, 32'h100 + x, 1'b0, 1'b0);
    issue(enc_fx(1, 1, 4'd1, 4'd2, 5'd0, 2'b01, 4'hF), 1'b0, 32'h100, x, 1'b0);
    expect_hint("R4", 1'b0, 32'h100, 1'b0, 1'b0);
    issue(enc_fx(1, 1, 4'd1, 4'd2, 5'd0, 2'b10, 4'hF), 1'b0, 32'h100, x, 1'b0);
    expect_hint("R4", 1'b0, 32'h100 + 32'hFFFF_FFFF, 1'b0, 1'b0);
    issue(enc_fx(1, 1, 4'd1, 4'd2, 5'd0, 2'b11, 4'hF), 1'b0, 32'h0, x, 1'b1);
    expect_hint("R4", 1'b0, 32'hC000_0001, 1'b0, 1'b0);
    issue(enc_fx(1, 1, 4'd1, 4'd2, 5'd0, 2'b11, 4'hF), 1'b0, 32'h0, x, 1'b0);
    expect_hint("R4", 1'b0, 32'h4000_0001, 1'b0, 1'b0);
  endtask

  task automatic t_fixed_unpred();
    issue(enc_fx(1, 1, 4'd1, 4'hF, 5'd0, 2'b00, 4'hF), 1'b0, 32'h40, 32'h4, 1'b0);
    expect_hint("R5", 1'b0, 32'h44, 1'b1, 1'b0);
    issue(enc_fx(1, 0, 4'hF, 4'd2, 5'd0, 2'b00, 4'hF), 1'b0, 32'h40, 32'h4, 1'b0);
    expect_hint("R5", 1'b1, 32'h44, 1'b1, 1'b0);
    issue(enc_fx(1, 1, 4'hF, 4'd2, 5'd0, 2'b00, 4'hF), 1'b0, 32'h8008, 32'h4, 1'b0);
    expect_hint("R5", 1'b0, 32'h800C, 1'b0, 1'b0);
  endtask

  task automatic t_fixed_reserved();
    issue(enc_fx(1, 1, 4'd3, 4'd4, 5'd0, 2'b00, 4'h0), 1'b0, 32'h200, 32'h8, 1'b0);
    expect_hint("R6", 1'b0, 32'h208, 1'b0, 1'b1);
  endtask

  task automatic t_compact();
    issue(enc_cp(1'b0, 4'd2, 2'd3, 4'd5), 1'b1, 32'h3000, 32'h11, 1'b1);
    expect_hint("R7", 1'b0, 32'h3088, 1'b0, 1'b0);
    issue(enc_cp(1'b1, 4'd2, 2'd0, 4'd5), 1'b1, 32'hFFFF_FFFF, 32'h2, 1'b0);
    expect_hint("R7", 1'b1, 32'h1, 1'b0, 1'b0);
  endtask

  task automatic t_compact_literal();
    issue(enc_cp(1'b0, 4'hF, 2'd1, 4'd5), 1'b1, 32'h3000, 32'h11, 1'b0);
    chk("R8", "redirect", 32'(o_l), 32'd1);
    chk("R8", "no hint", 32'(o_v), 32'd0);
    @(posedge clk); #1;
    chk("R8", "redirect pulse ends", 32'(lit_redirect), 32'd0);
  endtask

  task automatic t_compact_unpred();
    issue(enc_cp(1'b0, 4'd1, 2'd2, 4'hF), 1'b1, 32'h100, 32'h1, 1'b0);
    expect_hint("R9", 1'b0, 32'h104, 1'b1, 1'b0);
  endtask

  task automatic t_nomatch();
    logic [31:0] w;
    issue(32'hE590_1000, 1'b0, 32'h1, 32'h1, 1'b0);
    chk("R10", "junk word", 32'(o_v | o_l), 32'd0);
    w = enc_fx(1, 1, 4'd1, 4'd2, 5'd0, 2'b00, 4'hF);
    issue(w | 32'h10, 1'b0, 32'h1, 32'h1, 1'b0);
    chk("R10", "bit4 set", 32'(o_v | o_l), 32'd0);
    issue(enc_cp(1'b0, 4'd1, 2'd0, 4'd2) | 32'h40, 1'b1, 32'h1, 32'h1, 1'b0);
    chk("R10", "compact mid bits", 32'(o_v | o_l), 32'd0);
    issue(w, 1'b1, 32'h1, 32'h1, 1'b0);
    chk("R10", "wrong form flag", 32'(o_v | o_l), 32'd0);
    issue(w, 1'b0, 32'h1, 32'h1, 1'b0, 1'b0);
    chk("R10", "in_valid low", 32'(o_v | o_l), 32'd0);
  endtask

  task automatic t_indices();
    @(negedge clk);
    in_word = enc_fx(1, 1, 4'd9, 4'd6, 5'd0, 2'b00, 4'hF); in_compact = 1'b0;
    #1;
    chk("R11", "base sel fixed", 32'(rf_base_sel), 32'd9);
    chk("R11", "index sel fixed", 32'(rf_index_sel), 32'd6);
    in_word = enc_cp(1'b0, 4'd12, 2'd0, 4'd3); in_compact = 1'b1;
    #1;
    chk("R11", "base sel compact", 32'(rf_base_sel), 32'd12);
    chk("R11", "index sel compact", 32'(rf_index_sel), 32'd3);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    in_word = enc_cp(1'b0, 4'hF, 2'd0, 4'd1); in_compact = 1'b1; in_valid = 1'b1; rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R12", "redirect held in reset", 32'(lit_redirect), 32'd0);
    in_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin : watchdog
    #2_000_000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_fixed_basic();
    t_fixed_sub_wrap();
    t_fixed_shifts();
    t_fixed_zero_amt();
    t_fixed_unpred();
    t_fixed_reserved();
    t_compact();
    t_compact_literal();
    t_compact_unpred();
    t_nomatch();
    t_indices();
    t_reset_mid();
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule